// File: doc/BRIEF.md
# OLED power and initialization sequencer

This block sits on the host side of a small OLED display driver. It controls the power and start-up order of that driver. It drives the enable of the driver's logic supply, the enable of the panel drive supply and the driver's active-low reset line. It also produces a byte stream toward a separate bus interface block. That block turns each byte into a command or data transfer on the physical bus. Each byte travels with a flag that says whether it is a command or a data byte. Transfers use a valid/ready handshake.

A power-up request runs the whole start-up. It switches on the logic supply and holds the driver in reset for a fixed number of milliseconds, then releases reset. It then sends a fixed list of configuration commands and overwrites display memory with zero bytes. After that it switches on the panel supply, waits for that supply to settle and sends the display-on command. The configuration list has two variants. One suits a panel supply made by the driver's own charge pump, the other an external panel supply. A power-down request sends display-off, removes the panel supply, waits for the panel to discharge and then removes the logic supply. A prescaler derived from the system clock times every wait, so the delays are set in milliseconds.

Top module: `oled_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `logic_en`, `panel_en`, `drv_rst_n`, `tx_valid`, `busy` and `done` are all 0.
- R2: An `up_req` seen while fully off sets `logic_en` from the next cycle on. `drv_rst_n` stays 0 for exactly RST_MS*CLK_PER_MS+1 cycles from that point. No byte is offered while `drv_rst_n` is 0. `drv_rst_n` rises in the same cycle as the first command is offered.
- R3: After reset release, 22 command bytes (`tx_is_data`=0) are offered in this order: AE 00 10 40 81 <CONTRAST> A1 A6 A8 3F D3 00 D5 80 D9 <precharge> DA 12 DB 40 8D <pump>. CONTRAST is a parameter (default CF).
- R4: `ext_pump` is sampled with `up_req`. When it is 0 (internal pump), the precharge byte is F1 and the pump byte is 14. When it is 1 (external supply), they are 22 and 10. Later changes of `ext_pump` have no effect on that power-up.
- R5: After the list, CLEAR_BYTES bytes of value 00 are offered with `tx_is_data`=1. `panel_en` is still 0 while this happens.
- R6: `panel_en` rises in the cycle after the last clear byte is accepted. Display-on (AF, command) is offered after PANEL_MS*CLK_PER_MS+1 cycles with `panel_en` high. Its acceptance makes `done`=1 and `busy`=0 from the next cycle on.
- R7: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_is_data` hold their values. The sequence advances only on a cycle with both `tx_valid` and `tx_ready` high.
- R8: A `down_req` while on (`done`=1) offers display-off (AE, command) with `busy`=1 and `done`=0. On its acceptance `panel_en` falls. After DISCH_MS*CLK_PER_MS+1 more cycles `logic_en` falls, `drv_rst_n` stays 0, and `busy` returns to 0.
- R9: A `down_req` that arrives during power-up is remembered. `done` is then high for exactly one cycle, after which the power-down order starts.
- R10: `up_req` is ignored unless the block is fully off. `down_req` is ignored when fully off or while powering down.
- R11: `busy` is 1 in every cycle of either sequence and 0 only when fully off or fully on. `busy` and `done` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req | input | 1 | Start the power-up order (single-cycle pulse) |
| down_req | input | 1 | Start the power-down order (single-cycle pulse) |
| ext_pump | input | 1 | 1 = external panel supply, 0 = driver's internal charge pump |
| tx_ready | input | 1 | Downstream bus block can take the offered byte |
| tx_valid | output | 1 | A byte is offered |
| tx_data | output | 8 | Offered byte |
| tx_is_data | output | 1 | 1 = display data byte, 0 = command byte |
| logic_en | output | 1 | Enable of the driver logic supply |
| panel_en | output | 1 | Enable of the panel drive supply |
| drv_rst_n | output | 1 | Active-low reset of the display driver |
| busy | output | 1 | A power-up or power-down order is in progress |
| done | output | 1 | Power-up complete, display on |

## Verification
The bench builds the block with CLK_PER_MS=3, RST_MS=2, PANEL_MS=3, DISCH_MS=2 and CLEAR_BYTES=8. With these values every millisecond wait lasts only a few cycles and the memory clear is short. Complete up and down orders therefore repeat several times in one run, in both supply modes and under both a stalling and an always-ready downstream. The exact cycle counts at each wait boundary are checked, along with the last-clear-byte to panel-on transition. Requests are also timed to land inside reset hold and discharge, so the latched power-down request and the ignored requests are covered.

// File: rtl/oled_seq_pkg.sv
// Package: shared state type, command constants and the computed start-up
// list of the OLED power sequencer. Assumes an 8-bit command stream.
package oled_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,      // all supplies off, driver held in reset
        S_RST,      // logic supply on, reset held low for a fixed time
        S_INIT,     // configuration list streaming
        S_CLR,      // zero bytes to display memory
        S_PWAIT,    // panel supply on, settling wait
        S_DON,      // display-on command offered
        S_ON,       // running
        S_DOFF,     // display-off command offered
        S_DWAIT     // panel supply off, discharge wait
    } seq_state_t;

    localparam int          LIST_LEN   = 22;
    localparam logic [7:0]  CMD_DSP_ON = 8'hAF;
    localparam logic [7:0]  CMD_DSP_OFF = 8'hAE;

    // Returns one byte of the configuration list; ext selects the supply variant.
    function automatic logic [7:0] list_byte(input logic [4:0] idx,
                                             input logic       ext,
                                             input logic [7:0] contrast);
        logic [7:0] b;
        case (idx)
            5'd0:    b = CMD_DSP_OFF;
            5'd1:    b = 8'h00;
            5'd2:    b = 8'h10;
            5'd3:    b = 8'h40;
            5'd4:    b = 8'h81;
            5'd5:    b = contrast;
            5'd6:    b = 8'hA1;
            5'd7:    b = 8'hA6;
            5'd8:    b = 8'hA8;
            5'd9:    b = 8'h3F;
            5'd10:   b = 8'hD3;
            5'd11:   b = 8'h00;
            5'd12:   b = 8'hD5;
            5'd13:   b = 8'h80;
            5'd14:   b = 8'hD9;
            5'd15:   b = ext ? 8'h22 : 8'hF1;
            5'd16:   b = 8'hDA;
            5'd17:   b = 8'h12;
            5'd18:   b = 8'hDB;
            5'd19:   b = 8'h40;
            5'd20:   b = 8'h8D;
            5'd21:   b = ext ? 8'h10 : 8'h14;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/oled_ms_prescale.sv
// Millisecond prescaler: pulses tick once every CLK_PER_MS cycles while run
// is high and restarts from zero whenever run is low. Assumes CLK_PER_MS >= 2.
module oled_ms_prescale #(
    parameter int CLK_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = $clog2(CLK_PER_MS);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] pre;

    // Count clock cycles inside one millisecond, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            pre <= '0;
        else if (pre == LAST)
            pre <= '0;
        else
            pre <= pre + 1'b1;
    end

    assign tick = run && (pre == LAST);
endmodule

// File: rtl/oled_ms_count.sv
// Millisecond counter: counts ticks while run is high, saturating at limit;
// expired is high once limit milliseconds have elapsed. Cleared when run is low.
module oled_ms_count #(
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [MS_W-1:0] limit,
    output logic            expired
);
    logic [MS_W-1:0] ms;

    // Accumulate elapsed milliseconds up to the requested limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            ms <= '0;
        else if (tick && ms != limit)
            ms <= ms + 1'b1;
    end

    assign expired = run && (ms == limit);
endmodule

// File: rtl/oled_pwr_seq.sv
// OLED power and initialization sequencer (top).
// Orders the logic supply, the driver reset, the configuration list, the
// memory clear, the panel supply and display-on; on request runs the reverse.
// Assumes a downstream bus block with a valid/ready byte handshake, and
// request inputs that are single-cycle pulses.
module oled_pwr_seq
    import oled_seq_pkg::*;
#(
    parameter int         CLK_PER_MS  = 50000,
    parameter int         RST_MS      = 10,
    parameter int         PANEL_MS    = 100,
    parameter int         DISCH_MS    = 100,
    parameter int         CLEAR_BYTES = 1024,
    parameter logic [7:0] CONTRAST    = 8'hCF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_req,
    input  logic       down_req,
    input  logic       ext_pump,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_is_data,
    output logic       logic_en,
    output logic       panel_en,
    output logic       drv_rst_n,
    output logic       busy,
    output logic       done
);
    localparam int MS_MAX = (RST_MS > PANEL_MS) ?
                            ((RST_MS > DISCH_MS) ? RST_MS : DISCH_MS) :
                            ((PANEL_MS > DISCH_MS) ? PANEL_MS : DISCH_MS);
    localparam int MS_W   = $clog2(MS_MAX + 1);
    localparam int CW     = (CLEAR_BYTES > 1) ? $clog2(CLEAR_BYTES) : 1;
    localparam logic [CW-1:0] CLR_LAST  = CW'(CLEAR_BYTES - 1);
    localparam logic [4:0]    LIST_LAST = 5'(LIST_LEN - 1);

    seq_state_t      state;
    logic [4:0]      idx;
    logic [CW-1:0]   clr_cnt;
    logic            mode_ext;
    logic            pend_down;
    logic            hs;
    logic            wait_run;
    logic            ms_tick;
    logic            wait_done;
    logic [MS_W-1:0] wait_ms;

    assign hs       = tx_valid && tx_ready;
    assign wait_run = (state == S_RST) || (state == S_PWAIT) || (state == S_DWAIT);

    // Select the length of the wait that belongs to the current state.
    always_comb begin
        case (state)
            S_RST:   wait_ms = MS_W'(RST_MS);
            S_PWAIT: wait_ms = MS_W'(PANEL_MS);
            default: wait_ms = MS_W'(DISCH_MS);
        endcase
    end

    oled_ms_prescale #(.CLK_PER_MS(CLK_PER_MS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wait_run),
        .tick  (ms_tick)
    );

    oled_ms_count #(.MS_W(MS_W)) u_ms (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .tick    (ms_tick),
        .limit   (wait_ms),
        .expired (wait_done)
    );

    // Main sequence: advance on wait expiry or on an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_OFF;
            idx      <= '0;
            clr_cnt  <= '0;
            mode_ext <= 1'b0;
        end else begin
            case (state)
                S_OFF: if (up_req) begin
                    state    <= S_RST;
                    mode_ext <= ext_pump;
                    idx      <= '0;
                end
                S_RST: if (wait_done) state <= S_INIT;
                S_INIT: if (hs) begin
                    if (idx == LIST_LAST) begin
                        state   <= S_CLR;
                        clr_cnt <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_CLR: if (hs) begin
                    if (clr_cnt == CLR_LAST) state <= S_PWAIT;
                    else                     clr_cnt <= clr_cnt + 1'b1;
                end
                S_PWAIT: if (wait_done) state <= S_DON;
                S_DON:   if (hs) state <= S_ON;
                S_ON:    if (down_req || pend_down) state <= S_DOFF;
                S_DOFF:  if (hs) state <= S_DWAIT;
                S_DWAIT: if (wait_done) state <= S_OFF;
                default: state <= S_OFF;
            endcase
        end
    end

    // Remember a power-down request that arrives while powering up.
    always_ff @(posedge clk) begin
        if (!rst_n || state == S_ON)
            pend_down <= 1'b0;
        else if (down_req && (state == S_RST || state == S_INIT || state == S_CLR ||
                              state == S_PWAIT || state == S_DON))
            pend_down <= 1'b1;
    end

    // Drive the stream and the supply controls from the current state.
    always_comb begin
        tx_valid   = 1'b0;
        tx_data    = 8'h00;
        tx_is_data = 1'b0;
        case (state)
            S_INIT: begin
                tx_valid = 1'b1;
                tx_data  = list_byte(idx, mode_ext, CONTRAST);
            end
            S_CLR: begin
                tx_valid   = 1'b1;
                tx_is_data = 1'b1;
            end
            S_DON: begin
                tx_valid = 1'b1;
                tx_data  = CMD_DSP_ON;
            end
            S_DOFF: begin
                tx_valid = 1'b1;
                tx_data  = CMD_DSP_OFF;
            end
            default: ;
        endcase
        logic_en  = (state != S_OFF);
        drv_rst_n = (state != S_OFF) && (state != S_RST);
        panel_en  = (state == S_PWAIT) || (state == S_DON) ||
                    (state == S_ON)    || (state == S_DOFF);
        busy      = (state != S_OFF) && (state != S_ON);
        done      = (state == S_ON);
    end
endmodule

// File: rtl/oled_pwr_seq_chk.sv
// Checker for the OLED power sequencer: temporal rules on its ports.
// Attached to every instance of the top module by the bind below.
module oled_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       tx_is_data,
    input logic       logic_en,
    input logic       panel_en,
    input logic       drv_rst_n,
    input logic       busy,
    input logic       done
);
    // R7: an offered byte that is not taken stays unchanged
    a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_is_data));

    // R2: nothing is offered while the driver is in reset
    a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_rst_n |-> !tx_valid);

    // R6: the panel supply is only on with logic supply on and reset released
    a_r6_panel_order: assert property (@(posedge clk) disable iff (!rst_n)
        panel_en |-> logic_en && drv_rst_n);

    // R5: memory clear bytes are zero and precede the panel supply
    a_r5_clear_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_is_data |-> !panel_en && tx_data == 8'h00);

    // R11: busy and done exclude each other
    a_r11_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R8: the logic supply drops only after the panel supply was already off
    a_r8_logic_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(logic_en) |-> !panel_en && $past(!panel_en));
endmodule

bind oled_pwr_seq oled_pwr_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_is_data (tx_is_data),
    .logic_en   (logic_en),
    .panel_en   (panel_en),
    .drv_rst_n  (drv_rst_n),
    .busy       (busy),
    .done       (done)
);

// File: tb/oled_pwr_seq_test.sv
// Bench: behavioural reference model (queue of expected bytes, integer
// phases and cycle counters) compared with the outputs on every clock.
module oled_pwr_seq_test;
    localparam int C   = 3;
    localparam int RMS = 2;
    localparam int PMS = 3;
    localparam int DMS = 2;
    localparam int NCL = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_req = 1'b0;
    logic       down_req = 1'b0;
    logic       ext_pump = 1'b0;
    logic       tx_ready = 1'b1;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_is_data;
    logic       logic_en;
    logic       panel_en;
    logic       drv_rst_n;
    logic       busy;
    logic       done;

    int n_chk  = 0;
    int n_fail = 0;
    logic rdy_rand = 1'b0;
    logic [7:0] lf = 8'hA5;

    always #2 clk = ~clk;

    oled_pwr_seq #(
        .CLK_PER_MS(C), .RST_MS(RMS), .PANEL_MS(PMS),
        .DISCH_MS(DMS), .CLEAR_BYTES(NCL), .CONTRAST(8'hCF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
        .ext_pump(ext_pump), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_is_data(tx_is_data), .logic_en(logic_en),
        .panel_en(panel_en), .drv_rst_n(drv_rst_n), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ---------------- reference model ----------------
    // phases: 0 off, 1 reset hold, 2 streaming list+clear, 4 panel settle,
    // 5 display-on offered, 6 on, 7 display-off offered, 8 discharge
    int         m_ph = 0;
    int         m_cnt = 0;
    logic       m_pend = 1'b0;
    logic [8:0] m_q[$];
    logic       h_pend = 1'b0;
    logic [8:0] h_val = '0;

    function automatic void load_list(input logic ext);
        logic [7:0] l [22];
        l = '{8'hAE, 8'h00, 8'h10, 8'h40, 8'h81, 8'hCF, 8'hA1, 8'hA6,
              8'hA8, 8'h3F, 8'hD3, 8'h00, 8'hD5, 8'h80, 8'hD9,
              (ext ? 8'h22 : 8'hF1), 8'hDA, 8'h12, 8'hDB, 8'h40, 8'h8D,
              (ext ? 8'h10 : 8'h14)};
        m_q.delete();
        foreach (l[i]) m_q.push_back({1'b0, l[i]});
        for (int i = 0; i < NCL; i++) m_q.push_back(9'h100);
    endfunction

    always @(posedge clk) begin
        int  ph;
        logic pend_old;
        h_pend = tx_valid && !tx_ready;
        h_val  = {tx_is_data, tx_data};
        ph = m_ph;
        pend_old = m_pend;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_pend = 1'b0;
        end else begin
            if (ph == 6) m_pend = 1'b0;
            else if (down_req && ph >= 1 && ph <= 5) m_pend = 1'b1;
            case (ph)
                0: if (up_req) begin m_ph = 1; m_cnt = 0; load_list(ext_pump); end
                1: if (m_cnt == RMS * C) m_ph = 2; else m_cnt++;
                2: if (tx_ready) begin
                       void'(m_q.pop_front());
                       if (m_q.size() == 0) begin m_ph = 4; m_cnt = 0; end
                   end
                4: if (m_cnt == PMS * C) m_ph = 5; else m_cnt++;
                5: if (tx_ready) m_ph = 6;
                6: if (down_req || pend_old) m_ph = 7;
                7: if (tx_ready) begin m_ph = 8; m_cnt = 0; end
                8: if (m_cnt == DMS * C) m_ph = 0; else m_cnt++;
                default: m_ph = 0;
            endcase
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        logic       e_v;
        logic [8:0] e_b;
        string      st;
        e_v = (m_ph == 2) || (m_ph == 5) || (m_ph == 7);
        e_b = (m_ph == 2) ? m_q[0] : (m_ph == 5) ? 9'h0AF : (m_ph == 7) ? 9'h0AE : 9'h000;
        st  = (m_ph == 2) ? (e_b[8] ? "R5" : "R3 R4") :
              (m_ph == 5) ? "R6" : (m_ph == 7) ? "R8" : "R1";
        chk({st, " tx_valid"}, tx_valid, e_v);
        if (e_v) chk({st, " byte"}, {tx_is_data, tx_data}, e_b);
        chk("R2 logic_en", logic_en, m_ph != 0);
        chk("R2 drv_rst_n", drv_rst_n, m_ph >= 2);
        chk("R6 panel_en", panel_en, m_ph >= 4 && m_ph <= 7);
        chk("R11 busy", busy, m_ph != 0 && m_ph != 6);
        chk("R9 done", done, m_ph == 6);
        if (rst_n && h_pend) begin
            chk("R7 held valid", tx_valid, 1);
            chk("R7 held byte", {tx_is_data, tx_data}, h_val);
        end
    end

    // ---------------- stimulus ----------------
    initial forever begin
        @(negedge clk);
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        tx_ready = rdy_rand ? lf[0] : 1'b1;
    end

    task automatic pulse_up();
        @(negedge clk) up_req = 1'b1;
        @(negedge clk) up_req = 1'b0;
    endtask

    task automatic pulse_down();
        @(negedge clk) down_req = 1'b1;
        @(negedge clk) down_req = 1'b0;
    endtask

    task automatic wait_ph(input int p);
        while (m_ph != p) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 logic_en in reset", logic_en, 0);
        chk("R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drv_rst_n after reset", drv_rst_n, 0);

        // internal pump, stalling downstream
        rdy_rand = 1'b1;
        ext_pump = 1'b0;
        pulse_up();
        wait_ph(6);
        chk("R6 done after display-on", done, 1);
        pulse_up();
        @(negedge clk);
        chk("R10 up while on ignored", done, 1);
        pulse_down();
        wait_ph(0);
        chk("R8 logic off after discharge", logic_en, 0);
        pulse_down();
        @(negedge clk);
        chk("R10 down while off ignored", busy, 0);

        // external supply, mode changes after request, down latched in reset hold
        @(negedge clk) begin ext_pump = 1'b1; up_req = 1'b1; end
        @(negedge clk) begin ext_pump = 1'b0; up_req = 1'b0; end
        pulse_down();
        wait_ph(6);
        @(negedge clk);
        chk("R9 latched down served", tx_data, 8'hAE);
        chk("R9 done one cycle", done, 0);
        wait_ph(8);
        pulse_up();
        wait_ph(0);
        @(negedge clk);
        chk("R10 up in discharge ignored", logic_en, 0);

        // always-ready downstream
        rdy_rand = 1'b0;
        pulse_up();
        wait_ph(6);
        pulse_down();
        wait_ph(0);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule